// File: doc/BRIEF.md
# Synchronous Peripheral Enable Clock and Cycle Aligner

This block derives a slow, free-running enable clock from the processor clock for slow peripherals that work only on the edges of that enable. One enable period spans a fixed number of processor clocks. The enable is low for the first part of the period and high for the rest, with 6 low and 4 high by default. The enable runs in every cycle, whether or not the bus is busy.

The block also turns an asynchronous bus cycle aimed at such a peripheral into one aligned with the enable. When the address strobe and the synchronous-device indication are sampled together, the block raises a valid-memory-address output at a point in a low phase of the enable. It keeps that output high through the next complete high phase. In the last clock of that high phase it pulses a transfer-acknowledge, which ends the bus cycle. On a read it also pulses a data-latch strobe. A build option removes the valid-memory-address output and leaves it to logic outside the block.

Top module: `e_sync_bridge`

## Requirements
- R1: During and directly after reset the enable, valid-address, acknowledge and latch outputs are all low. The phase counter starts at position 0, the first low clock of a period.
- R2: The enable repeats with a period of LOW_CYC+HIGH_CYC clocks: LOW_CYC clocks low (positions 0..LOW_CYC-1), then HIGH_CYC clocks high. It runs the same way whatever the bus inputs do.
- R3: A request is address strobe and synchronous-device indication both high at a rising clock edge while the block is idle. If the phase position sampled at that edge is LOW_CYC-2 or earlier, the valid-address output goes high from that edge.
- R4: A request sampled at phase position LOW_CYC-1 or in the high phase waits. The valid-address output then goes high at the edge where the enable falls.
- R5: The acknowledge is a single-clock pulse in the last high clock (position LOW_CYC+HIGH_CYC-1) of the first complete high phase after the valid-address output went high.
- R6: The valid-address output falls at the same edge where the enable falls after the acknowledge pulse.
- R7: The latch strobe pulses together with the acknowledge only when the read/write input is high (1 = read). On a write it stays low.
- R8: An address strobe without the synchronous-device indication, or the indication without the strobe, produces no valid-address output and no acknowledge.
- R9: After a cycle ends, no new cycle starts until the address strobe has been sampled low at least once.
- R10: With HAS_VMA=0 the valid-address output is held low. The acknowledge and latch timing does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_i | input | 1 | Address strobe, active high |
| vpa_i | input | 1 | Addressed device is synchronous, active high |
| rnw_i | input | 1 | 1 = read, 0 = write |
| e_o | output | 1 | Free-running enable clock |
| vma_o | output | 1 | Valid address, aligned to the enable |
| dack_o | output | 1 | One-clock acknowledge that ends the bus cycle |
| rd_latch_o | output | 1 | Read data latch strobe |

## Verification
Requests are started at each phase position of the enable: early in the low phase, at the last early position, at the last low clock, and at several high positions. This separates immediate assertion of the valid-address output from the deferred case, and shows where the boundary between them lies. Each of these is run as a read and as a write, which separates the latch strobe from the plain acknowledge. Strobe-only and indication-only stimuli check that no cycle starts from one input alone. Long and zero strobe holds after a cycle check that a new cycle needs the strobe to go low first. A second instance built without the valid-address output runs the same stimulus, so its acknowledge timing can be compared with the full variant.

// File: rtl/e_sync_pkg.sv
package e_sync_pkg;

   typedef enum logic [1:0] {
      HS_IDLE   = 2'd0,
      HS_WAIT   = 2'd1,
      HS_ACTIVE = 2'd2,
      HS_DONE   = 2'd3
   } hs_state_t;

   function automatic int unsigned phase_bits(input int unsigned period);
      int unsigned w;
      w = 1;
      while ((1 << w) < period) w++;
      return w;
   endfunction

endpackage

// File: rtl/e_phase_gen.sv
module e_phase_gen #(
   parameter int unsigned LOW_CYC  = 6,
   parameter int unsigned HIGH_CYC = 4,
   localparam int unsigned PERIOD  = LOW_CYC + HIGH_CYC,
   localparam int unsigned PW      = e_sync_pkg::phase_bits(PERIOD)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [PW-1:0] phase_o,
   output logic          e_o,
   output logic          early_o,
   output logic          last_o
);

   localparam logic [PW-1:0] LAST_POS  = PW'(PERIOD - 1);
   localparam logic [PW-1:0] FIRST_HI  = PW'(LOW_CYC);
   localparam logic [PW-1:0] EARLY_MAX = PW'(LOW_CYC - 2);

   logic [PW-1:0] phase_q;

   // any position at or beyond the last legal one returns to zero,
   // so an out-of-range value recovers within one clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (phase_q >= LAST_POS)
         phase_q <= '0;
      else
         phase_q <= phase_q + PW'(1);
   end

   assign phase_o = phase_q;
   assign e_o     = (phase_q >= FIRST_HI) && (phase_q <= LAST_POS);
   assign early_o = (phase_q <= EARLY_MAX);
   assign last_o  = (phase_q == LAST_POS);

endmodule

// File: rtl/sync_hs_fsm.sv
module sync_hs_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic as_i,
   input  logic vpa_i,
   input  logic rnw_i,
   input  logic early_i,
   input  logic last_i,
   output logic window_o,
   output logic dack_o,
   output logic rd_latch_o
);
   import e_sync_pkg::*;

   hs_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         HS_IDLE: begin
            if (as_i && vpa_i)
               state_d = early_i ? HS_ACTIVE : HS_WAIT;
         end
         HS_WAIT: begin
            if (last_i) state_d = HS_ACTIVE;
         end
         HS_ACTIVE: begin
            if (last_i) state_d = HS_DONE;
         end
         HS_DONE: begin
            if (!as_i) state_d = HS_IDLE;
         end
         default: state_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= HS_IDLE;
      else        state_q <= state_d;
   end

   assign window_o   = (state_q == HS_ACTIVE);
   assign dack_o     = (state_q == HS_ACTIVE) && last_i;
   assign rd_latch_o = dack_o && rnw_i;

endmodule

// File: rtl/e_sync_bridge.sv
module e_sync_bridge #(
   parameter int unsigned LOW_CYC  = 6,
   parameter int unsigned HIGH_CYC = 4,
   parameter bit          HAS_VMA  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic as_i,
   input  logic vpa_i,
   input  logic rnw_i,
   output logic e_o,
   output logic vma_o,
   output logic dack_o,
   output logic rd_latch_o
);
   localparam int unsigned PERIOD = LOW_CYC + HIGH_CYC;
   localparam int unsigned PW     = e_sync_pkg::phase_bits(PERIOD);

   if (LOW_CYC < 2) begin : g_bad_low
      $error("e_sync_bridge: LOW_CYC must be at least 2");
   end
   if (HIGH_CYC < 1) begin : g_bad_high
      $error("e_sync_bridge: HIGH_CYC must be at least 1");
   end

   logic [PW-1:0] phase;
   logic          early, last, window;

   e_phase_gen #(
      .LOW_CYC  (LOW_CYC),
      .HIGH_CYC (HIGH_CYC)
   ) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_o (phase),
      .e_o     (e_o),
      .early_o (early),
      .last_o  (last)
   );

   sync_hs_fsm u_hs (
      .clk        (clk),
      .rst_n      (rst_n),
      .as_i       (as_i),
      .vpa_i      (vpa_i),
      .rnw_i      (rnw_i),
      .early_i    (early),
      .last_i     (last),
      .window_o   (window),
      .dack_o     (dack_o),
      .rd_latch_o (rd_latch_o)
   );

   if (HAS_VMA) begin : g_vma
      assign vma_o = window;
   end else begin : g_no_vma
      logic unused_window;
      assign unused_window = window;
      assign vma_o = 1'b0;
   end

   logic unused_phase;
   assign unused_phase = ^phase;

endmodule

// File: rtl/e_sync_bridge_chk.sv
module e_sync_bridge_chk #(
   parameter int unsigned LOW_CYC  = 6,
   parameter int unsigned HIGH_CYC = 4,
   parameter bit          HAS_VMA  = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic rnw_i,
   input logic e_o,
   input logic vma_o,
   input logic dack_o,
   input logic rd_latch_o
);
   int unsigned lo_run, hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_run <= 0;
         hi_run <= 0;
      end else if (e_o) begin
         lo_run <= 0;
         hi_run <= hi_run + 1;
      end else begin
         hi_run <= 0;
         lo_run <= lo_run + 1;
      end
   end

   AST_E_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(e_o) |-> (lo_run == LOW_CYC)); // R2
   AST_E_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(e_o) |-> (hi_run == HIGH_CYC)); // R2
   AST_DACK_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      dack_o |-> e_o); // R5
   AST_DACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      dack_o |=> !dack_o); // R5
   AST_DACK_THEN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      dack_o |=> $fell(e_o)); // R6
   AST_LATCH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_latch_o |-> (dack_o && rnw_i)); // R7

   if (HAS_VMA) begin : g_vma_chk
      AST_VMA_RISE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(vma_o) |-> !e_o); // R3
      AST_VMA_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(vma_o) |-> $fell(e_o)); // R6
      AST_DACK_NEEDS_VMA: assert property (@(posedge clk) disable iff (!rst_n)
         dack_o |-> vma_o); // R5
   end else begin : g_novma_chk
      AST_VMA_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         !vma_o); // R10
   end

endmodule

bind e_sync_bridge e_sync_bridge_chk #(
   .LOW_CYC  (LOW_CYC),
   .HIGH_CYC (HIGH_CYC),
   .HAS_VMA  (HAS_VMA)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rnw_i      (rnw_i),
   .e_o        (e_o),
   .vma_o      (vma_o),
   .dack_o     (dack_o),
   .rd_latch_o (rd_latch_o)
);

// File: tb/tb_e_sync_bridge.sv
module tb_e_sync_bridge;
   localparam int LOWC = 6;
   localparam int HIGHC = 4;
   localparam int PER = LOWC + HIGHC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic as_i = 1'b0, vpa_i = 1'b0, rnw_i = 1'b0;
   logic e_o, vma_o, dack_o, rd_latch_o;
   logic e_n, vma_n, dack_n, rd_latch_n;

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   // model state: 0 idle, 1 wait, 2 active, 3 done
   int m_ph = 0, m_st = 0;
   bit m_run = 1'b0;

   always #10 clk = ~clk;

   e_sync_bridge #(.LOW_CYC(LOWC), .HIGH_CYC(HIGHC), .HAS_VMA(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .as_i(as_i), .vpa_i(vpa_i), .rnw_i(rnw_i),
      .e_o(e_o), .vma_o(vma_o), .dack_o(dack_o), .rd_latch_o(rd_latch_o));

   e_sync_bridge #(.LOW_CYC(LOWC), .HIGH_CYC(HIGHC), .HAS_VMA(1'b0)) dut_nv (
      .clk(clk), .rst_n(rst_n), .as_i(as_i), .vpa_i(vpa_i), .rnw_i(rnw_i),
      .e_o(e_n), .vma_o(vma_n), .dack_o(dack_n), .rd_latch_o(rd_latch_n));

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      if (m_run) begin
         int nst;
         nst = m_st;
         case (m_st)
            0: if (as_i && vpa_i) nst = (m_ph <= LOWC - 2) ? 2 : 1;
            1: if (m_ph == PER - 1) nst = 2;
            2: if (m_ph == PER - 1) nst = 3;
            default: if (!as_i) nst = 0;
         endcase
         m_st = nst;
         m_ph = (m_ph + 1) % PER;
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   // compare every clock, away from both edges
   always @(posedge clk) begin
      if (m_run && rst_n) begin
         logic xe, xv, xd, xl;
         #2;
         xe = (m_ph >= LOWC);
         xv = (m_st == 2);
         xd = (m_st == 2) && (m_ph == PER - 1);
         xl = xd && rnw_i;
         chk("R2 enable", e_o, xe);
         chk("R3/R4/R6/R8/R9 vma", vma_o, xv);
         chk("R5 dack", dack_o, xd);
         chk("R7 rd_latch", rd_latch_o, xl);
         chk("R10 enable no-vma variant", e_n, xe);
         chk("R10 vma held low", vma_n, 1'b0);
         chk("R10 dack no-vma variant", dack_n, xd);
         chk("R10 latch no-vma variant", rd_latch_n, xl);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // start a request when the next sampled phase equals ph
   task automatic run_cycle(input int ph, input bit a, input bit v,
                            input bit r, input int extra_hold);
      int guard;
      guard = 0;
      @(negedge clk);
      while (m_ph != ph && guard < 40) begin
         @(negedge clk);
         guard++;
      end
      as_i = a; vpa_i = v; rnw_i = r;
      if (a && v) begin
         guard = 0;
         do begin
            @(negedge clk);
            guard++;
         end while (m_st != 3 && guard < 60);
      end else begin
         idle(2 * PER);
      end
      idle(extra_hold);
      as_i = 1'b0; vpa_i = 1'b0;
      idle(3);
   endtask

   initial begin
      #15;
      // R1: outputs low while reset is held
      chk("R1 enable in reset", e_o, 1'b0);
      chk("R1 vma in reset", vma_o, 1'b0);
      chk("R1 dack in reset", dack_o, 1'b0);
      chk("R1 latch in reset", rd_latch_o, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      m_run = 1'b1;
      #12;
      chk("R1 enable after reset", e_o, 1'b0);
      chk("R1 vma after reset", vma_o, 1'b0);
      idle(2 * PER + 3);               // R2 free running with idle bus
      run_cycle(0, 1, 1, 1, 0);        // R3 early read
      run_cycle(LOWC - 2, 1, 1, 0, 0); // R3 last early position, write
      run_cycle(LOWC - 1, 1, 1, 1, 0); // R4 last low clock defers
      run_cycle(LOWC, 1, 1, 0, 0);     // R4 first high clock
      run_cycle(PER - 1, 1, 1, 1, 0);  // R4 last high clock
      run_cycle(2, 1, 0, 1, 0);        // R8 strobe alone
      run_cycle(3, 0, 1, 1, 0);        // R8 indication alone
      run_cycle(1, 1, 1, 1, 25);       // R9 strobe held long after end
      for (int p = 0; p < PER; p++) begin
         run_cycle(p, 1, 1, p[0], 0);  // R3 R4 R5 R7 sweep
      end
      // R9 back-to-back: strobe dropped for one clock only
      @(negedge clk);
      as_i = 1'b1; vpa_i = 1'b1; rnw_i = 1'b1;
      idle(4 * PER);
      as_i = 1'b0;
      @(negedge clk);
      as_i = 1'b1;
      idle(4 * PER);
      as_i = 1'b0; vpa_i = 1'b0;
      idle(2 * PER);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired: actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule